// File: doc/BRIEF.md
# One-Time Write-Protect Guard

This block sits between the serial slave front end of a 256-byte non-volatile memory and its programming engine, and decides which transfers may program the array. The front end reports bus events as single-cycle strobes: start condition, device address (with its four-bit device-type code and read/write bit), byte address, each received data byte together with the internal address it targets, and a valid stop condition. The guard answers each strobe in the same cycle with an acknowledge enable, and at stop it either launches the programming cycle or does not.

Two independent protections are combined. A fuse-like lock flag, reset to a parameterised value and otherwise only ever set, shields the lower half of the array once set. It is reached by a dedicated device-type code that replaces the normal memory code; a plain single-byte write to that code with any byte address and any data sets it at the following valid stop, and after that the code is treated as a foreign device. An external write-protect pin, when high, overrides everything: no byte is programmed anywhere and the lock flag cannot be set, while the device address and byte address of a write are still acknowledged so that the refusal shows up at the first data byte.

Top module: `wp_guard`

## Requirements
- R1: After reset `lock_flag` equals the FLAG_INIT parameter (0 by default) and `dev_ack`, `addr_ack`, `data_ack`, `commit_en` and `lock_req` are all low.
- R2: A write with device-type code MEM_CODE (default 4'b1010, `dev_rd`=0) and the pin low acknowledges the device address, the byte address and every data byte aimed at a writable location, and `commit_en` is high in the cycle of the closing stop strobe.
- R3: With `lock_flag`=1 a data byte whose `byte_addr` has its most significant bit 0 (0x00 to 0x7F) is not acknowledged and the write is not committed; bytes at 0x80 to 0xFF are acknowledged and committed.
- R4: With `lock_flag`=0 and the pin low, a write to LOCK_CODE (default 4'b0110) acknowledges device address, byte address and data whatever their values; `lock_req` is high in the stop cycle, `commit_en` stays low, and `lock_flag` reads 1 from the next cycle on.
- R5: Once `lock_flag` is 1 it never returns to 0, and any later LOCK_CODE access gets no acknowledge on its device address, byte address or data and raises no `lock_req`.
- R6: With the pin high a MEM_CODE write still acknowledges device address and byte address, but no data byte is acknowledged and `commit_en` stays low at stop, whether `lock_flag` is 0 or 1.
- R7: With the pin high a LOCK_CODE write gets no data acknowledge, `lock_req` stays low and `lock_flag` keeps its value.
- R8: After one data byte of a write has been refused, every later data byte of the same transfer is refused and the stop does not commit, even when it targets a writable address.
- R9: A MEM_CODE read acknowledges its device address but never acknowledges data nor commits; a LOCK_CODE read is not acknowledged.
- R10: A start strobe ends the current transfer: a stop following a repeated start that carried no new write data raises neither `commit_en` nor `lock_req`.
- R11: A device address whose code is neither MEM_CODE nor LOCK_CODE is not acknowledged, and the bytes that follow it are not acknowledged either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_pin | input | 1 | External write-protect pin level, high blocks all programming |
| start_stb | input | 1 | Start or repeated start condition seen |
| dev_stb | input | 1 | Device address byte received |
| dev_code | input | 4 | Device-type code from the device address byte |
| dev_rd | input | 1 | Read/write bit of the device address, 1 = read |
| addr_stb | input | 1 | Byte address received |
| data_stb | input | 1 | Data byte received from the master |
| byte_addr | input | ADDR_W | Internal address targeted by the current data byte |
| stop_stb | input | 1 | Valid stop condition seen |
| dev_ack | output | 1 | Acknowledge the device address |
| addr_ack | output | 1 | Acknowledge the byte address |
| data_ack | output | 1 | Acknowledge the data byte |
| commit_en | output | 1 | Start the programming cycle of the received bytes |
| lock_req | output | 1 | Set the one-time lock flag |
| lock_flag | output | 1 | Current value of the lock flag |

## Verification
The bench builds the guard with its defaults: ADDR_W of 8, the memory and lock codes 4'b1010 and 4'b0110, and a clear initial flag. At that width the protected and open halves are split by bit 7, so random byte addresses with page rollover land on both sides of the boundary and writes of one to three bytes reach the refuse-then-continue case. The clear initial flag lets one run cover the pin-blocked attempt to lock, the single successful lock, and every later ignored lock access.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int          ADDR_W    = 8,
  parameter logic [3:0]  MEM_CODE  = 4'b1010,
  parameter logic [3:0]  LOCK_CODE = 4'b0110,
  parameter logic        FLAG_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              start_stb,
  input  logic              dev_stb,
  input  logic [3:0]        dev_code,
  input  logic              dev_rd,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              stop_stb,
  output logic              dev_ack,
  output logic              addr_ack,
  output logic              data_ack,
  output logic              commit_en,
  output logic              lock_req,
  output logic              lock_flag
);

  localparam int HI_BIT = ADDR_W - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_MEM_WR, S_MEM_RD, S_LOCK_WR, S_IGNORE
  } sess_t;

  sess_t sess_q;
  logic  flag_q;
  logic  got_q;
  logic  blk_q;

  logic is_mem, is_lock, wr_sess, in_prot, allow, ended;

  assign is_mem   = (dev_code == MEM_CODE);
  assign is_lock  = (dev_code == LOCK_CODE) && !flag_q;
  assign wr_sess  = (sess_q == S_MEM_WR) || (sess_q == S_LOCK_WR);
  assign in_prot  = !byte_addr[HI_BIT];
  assign allow    = !wp_pin && ((sess_q == S_LOCK_WR) || !(flag_q && in_prot));
  assign ended    = got_q && !blk_q && !wp_pin;

  assign dev_ack   = dev_stb && (is_mem || (is_lock && !dev_rd));
  assign addr_ack  = addr_stb && wr_sess;
  assign data_ack  = data_stb && wr_sess && !blk_q && allow;
  assign commit_en = stop_stb && (sess_q == S_MEM_WR) && ended;
  assign lock_req  = stop_stb && (sess_q == S_LOCK_WR) && ended;
  assign lock_flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_INIT;
      sess_q <= S_IDLE;
      got_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      if (lock_req)
        flag_q <= 1'b1;
      if (start_stb || stop_stb) begin
        sess_q <= S_IDLE;
        got_q  <= 1'b0;
        blk_q  <= 1'b0;
      end else if (dev_stb) begin
        got_q <= 1'b0;
        blk_q <= 1'b0;
        if (is_mem)
          sess_q <= dev_rd ? S_MEM_RD : S_MEM_WR;
        else if (is_lock && !dev_rd)
          sess_q <= S_LOCK_WR;
        else
          sess_q <= S_IGNORE;
      end else if (data_stb && wr_sess) begin
        if (data_ack)
          got_q <= 1'b1;
        else
          blk_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] LOCK_CODE = 4'b0110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_pin,
  input logic              start_stb,
  input logic              dev_stb,
  input logic [3:0]        dev_code,
  input logic              dev_rd,
  input logic              addr_stb,
  input logic              data_stb,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              stop_stb,
  input logic              dev_ack,
  input logic              addr_ack,
  input logic              data_ack,
  input logic              commit_en,
  input logic              lock_req,
  input logic              lock_flag
);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, dev_stb, addr_stb, data_stb, stop_stb}));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |=> lock_flag);

  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(lock_req));

  assert_locked_code_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb && dev_code == LOCK_CODE && lock_flag) |-> !dev_ack);

  assert_pin_refuses_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && wp_pin) |-> !data_ack);

  assert_low_half_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && lock_flag && !byte_addr[ADDR_W-1]) |-> !data_ack);

  assert_pin_blocks_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |-> !wp_pin);

  assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> !commit_en);

  assert_no_dual_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_en && lock_req));

endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W), .LOCK_CODE(LOCK_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .start_stb(start_stb),
  .dev_stb(dev_stb), .dev_code(dev_code), .dev_rd(dev_rd),
  .addr_stb(addr_stb), .data_stb(data_stb), .byte_addr(byte_addr),
  .stop_stb(stop_stb), .dev_ack(dev_ack), .addr_ack(addr_ack),
  .data_ack(data_ack), .commit_en(commit_en), .lock_req(lock_req),
  .lock_flag(lock_flag));

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;

  localparam logic [3:0] MEMC  = 4'b1010;
  localparam logic [3:0] LOCKC = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_pin = 1'b0;
  logic start_stb = 1'b0, dev_stb = 1'b0, addr_stb = 1'b0, data_stb = 1'b0, stop_stb = 1'b0;
  logic [3:0] dev_code = 4'h0;
  logic dev_rd = 1'b0;
  logic [7:0] byte_addr = 8'h00;
  logic dev_ack, addr_ack, data_ack, commit_en, lock_req, lock_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit mflag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .start_stb(start_stb),
    .dev_stb(dev_stb), .dev_code(dev_code), .dev_rd(dev_rd),
    .addr_stb(addr_stb), .data_stb(data_stb), .byte_addr(byte_addr),
    .stop_stb(stop_stb), .dev_ack(dev_ack), .addr_ack(addr_ack),
    .data_ack(data_ack), .commit_en(commit_en), .lock_req(lock_req),
    .lock_flag(lock_flag));

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe_end();
    @(posedge clk);
    #1;
    {start_stb, dev_stb, addr_stb, data_stb, stop_stb} = 5'b0;
  endtask

  task automatic ev_start();
    @(negedge clk); start_stb = 1'b1; #1; strobe_end();
  endtask

  task automatic ev_dev(input logic [3:0] c, input bit rd, output bit ack);
    @(negedge clk); dev_code = c; dev_rd = rd; dev_stb = 1'b1; #1; ack = dev_ack; strobe_end();
  endtask

  task automatic ev_addr(input logic [7:0] a, output bit ack);
    @(negedge clk); byte_addr = a; addr_stb = 1'b1; #1; ack = addr_ack; strobe_end();
  endtask

  task automatic ev_data(input logic [7:0] a, output bit ack);
    @(negedge clk); byte_addr = a; data_stb = 1'b1; #1; ack = data_ack; strobe_end();
  endtask

  task automatic ev_stop(output bit cm, output bit lk);
    @(negedge clk); stop_stb = 1'b1; #1; cm = commit_en; lk = lock_req; strobe_end();
  endtask

  function automatic logic [7:0] page_addr(input logic [7:0] a0, input int i);
    return {a0[7:4], 4'(a0[3:0] + 4'(i))};
  endfunction

  function automatic bit exp_dev(input logic [3:0] c, input bit rd);
    return (c == MEMC) || (c == LOCKC && !mflag && !rd);
  endfunction

  function automatic bit exp_byte(input logic [3:0] c, input bit pin, input logic [7:0] a);
    if (pin) return 1'b0;
    if (c == LOCKC) return 1'b1;
    return !(mflag && !a[7]);
  endfunction

  // Full write transfer with model-derived expectations
  task automatic wr_txn(input logic [3:0] c, input bit pin, input logic [7:0] a0,
                        input int n, input string req);
    bit ack, cm, lk, sel, got, blk, e;
    wp_pin = pin;
    sel = exp_dev(c, 1'b0);
    got = 1'b0; blk = 1'b0;
    ev_start();
    ev_dev(c, 1'b0, ack);   check(ack, sel, {req, " device address ack"});
    ev_addr(a0, ack);       check(ack, sel, {req, " byte address ack"});
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = page_addr(a0, i);
      e = sel && !blk && exp_byte(c, pin, a);
      ev_data(a, ack);      check(ack, e, {req, " data ack"});
      if (sel) begin if (e) got = 1'b1; else blk = 1'b1; end
    end
    ev_stop(cm, lk);
    e = sel && got && !blk && !pin;
    check(cm, e && c == MEMC, {req, " commit_en"});
    check(lk, e && c == LOCKC, {req, " lock_req"});
    if (e && c == LOCKC) mflag = 1'b1;
    @(negedge clk);
    check(lock_flag, mflag, {req, " lock_flag"});
    wp_pin = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack, cm, lk;
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    #1;
    check(lock_flag, 1'b0, "R1 flag after reset");
    check(dev_ack | addr_ack | data_ack | commit_en | lock_req, 1'b0, "R1 outputs idle in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(dev_ack | addr_ack | data_ack | commit_en | lock_req, 1'b0, "R1 outputs idle after reset");

    wr_txn(MEMC, 1'b0, 8'h1E, 3, "R2 page write low half");
    wr_txn(MEMC, 1'b0, 8'hA0, 1, "R2 byte write high half");

    // R9 reads
    ev_start(); ev_dev(LOCKC, 1'b1, ack); check(ack, 1'b0, "R9 lock code read not acked");
    ev_stop(cm, lk); check(lk, 1'b0, "R9 lock read no lock_req");
    ev_start(); ev_dev(MEMC, 1'b1, ack); check(ack, 1'b1, "R9 memory read acked");
    ev_data(8'h90, ack); check(ack, 1'b0, "R9 no data ack in read");
    ev_stop(cm, lk); check(cm, 1'b0, "R9 read never commits");

    // R11 foreign code
    wr_txn(4'b0101, 1'b0, 8'h40, 2, "R11 foreign code");

    // R6 and R7 with pin high before lock
    wr_txn(MEMC, 1'b1, 8'h85, 2, "R6 pin high unlocked");
    wr_txn(LOCKC, 1'b1, 8'h33, 1, "R7 pin blocks lock set");
    check(lock_flag, 1'b0, "R7 flag still clear");

    // R10 repeated start drops the transfer
    ev_start(); ev_dev(MEMC, 1'b0, ack); ev_addr(8'h22, ack);
    ev_data(8'h22, ack); check(ack, 1'b1, "R10 data acked before restart");
    ev_start(); ev_stop(cm, lk);
    check(cm, 1'b0, "R10 restart cancels commit");

    // random phase before lock
    for (int t = 0; t < 60; t++) begin
      logic [3:0] c;
      c = ($urandom % 8 == 0) ? 4'($urandom) : MEMC;
      if (c == LOCKC) c = MEMC;
      wr_txn(c, ($urandom % 3) == 0, 8'($urandom), 1 + int'($urandom % 3), "R2 random unlocked");
    end

    // R4 lock with don't-care fields
    wr_txn(LOCKC, 1'b0, 8'($urandom), 1, "R4 lock set");
    check(lock_flag, 1'b1, "R4 flag set after stop");

    // R5 later lock accesses ignored
    wr_txn(LOCKC, 1'b0, 8'h00, 1, "R5 relock ignored");
    ev_start(); ev_dev(LOCKC, 1'b0, ack); check(ack, 1'b0, "R5 lock code nacked");
    ev_addr(8'h12, ack); check(ack, 1'b0, "R5 lock byte address nacked");
    ev_data(8'h12, ack); check(ack, 1'b0, "R5 lock data nacked");
    ev_stop(cm, lk); check(lk, 1'b0, "R5 no lock_req");
    check(lock_flag, 1'b1, "R5 flag stays set");

    // R3 halves
    wr_txn(MEMC, 1'b0, 8'h20, 1, "R3 low half refused");
    wr_txn(MEMC, 1'b0, 8'h7F, 1, "R3 top of low half refused");
    wr_txn(MEMC, 1'b0, 8'h80, 2, "R3 high half accepted");
    wr_txn(MEMC, 1'b1, 8'hC0, 1, "R6 pin high locked");

    // R8 refused then writable
    ev_start(); ev_dev(MEMC, 1'b0, ack); ev_addr(8'h05, ack);
    ev_data(8'h05, ack); check(ack, 1'b0, "R8 first byte refused");
    ev_data(8'h85, ack); check(ack, 1'b0, "R8 later byte refused");
    ev_stop(cm, lk); check(cm, 1'b0, "R8 no commit");

    // random phase after lock
    for (int t = 0; t < 60; t++) begin
      logic [3:0] c;
      int k;
      k = int'($urandom % 8);
      c = (k == 0) ? LOCKC : (k == 1) ? 4'($urandom) : MEMC;
      wr_txn(c, ($urandom % 3) == 0, 8'($urandom), 1 + int'($urandom % 3), "R3 random locked");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule